// File: doc/BRIEF.md
# Eight-Channel Counter Interrupt Aggregator

This unit gathers the flag outputs of eight counter channels and turns them into one shareable interrupt request line. Each channel has a pending bit. The pending bit latches when the channel's flag is active and its enable bit is set. It then stays set until software clears it.

Software reaches the unit over a byte-wide write bus with a small address field. Reads are combinational from the same address.

- A status location reports the pending bits.
- An enable location holds one enable bit per channel.
- A command location takes global operations:
  - One command arms the interrupt function, starts counting and clears every pending bit.
  - Another command sends a reset pulse to the counters and disarms the interrupt function.

Channel n always maps to bit n of the status and enable bytes. The request line is high only while the function is armed and at least one pending bit is set.

Top module: `cnt_irq_agg`

## Requirements
- R1: After reset, `irq_o` is low, `count_run_o` and `count_rst_o` are low, the status byte (address 0x10) reads 0x00 and the enable byte (address 0x12) reads 0x00.
- R2: A read at address 0x10 returns the pending bits, with channel n on bit n. The value 0x00 means that nothing is pending.
- R3: A write at address 0x12 loads the enable mask, with channel n on bit n, and a read at 0x12 returns it. A channel whose enable bit is 0 never gains a pending bit. Writing 0x00 therefore stops all new latching.
- R4: When `flag_i[n]` is high (active high) on a clock edge and enable bit n is set, pending bit n reads 1 after that edge. This happens whether or not the interrupt function is armed.
- R5: A pending bit stays set after its flag goes low. It is cleared only by the arm command.
- R6: Writing 0x04 at address 0x11 arms the interrupt function, sets `count_run_o` and clears every pending bit from the next cycle on.
- R7: A flag that latches on the same edge as the arm command keeps its pending bit set after that edge.
- R8: Writing 0x01 at address 0x11 drives `count_rst_o` high for exactly one cycle and disarms the interrupt function. Pending bits and `count_run_o` are left unchanged.
- R9: `irq_o` is high exactly when the function is armed and at least one pending bit is set. It is low whenever the status byte is 0x00.
- R10: Any other value written at 0x11, and any write to another address, changes neither the pending bits, the enable mask nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register address for writes and reads |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| flag_i | input | 8 | Counter channel flags, active high, channel n on bit n |
| count_run_o | output | 1 | Counting enabled |
| count_rst_o | output | 1 | One-cycle counter reset pulse |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Two functions can fall on the same clock edge: a channel flag latching a pending bit, and the arm command clearing all pending bits. The bench provokes this by driving a flag in the same cycle as the 0x04 command write. It expects the status byte to hold only that channel's bit, while a bit that was set before the command is gone. A second overlap is the disarm command arriving while pending bits are set. There the line must drop on the next cycle while the status byte keeps its value.

// File: rtl/cnt_irq_pkg.sv
package cnt_irq_pkg;
    localparam int unsigned NCH    = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CHANOP = 5'h11;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h12;

    localparam logic [DATA_W-1:0] CMD_DISARM = 8'h01;
    localparam logic [DATA_W-1:0] CMD_ARM    = 8'h04;

    typedef struct packed {
        logic           armed;
        logic           run;
        logic           crst;
        logic [NCH-1:0] en;
    } ctrl_state_t;
endpackage

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl
    import cnt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCH-1:0]    en_mask,
    output logic              armed,
    output logic              run,
    output logic              crst,
    output logic              clr_req
);
    ctrl_state_t st_d, st_q;
    logic        chanop_wr;
    logic        en_wr;

    always_comb begin
        chanop_wr = wr && (addr == OFS_CHANOP);
        en_wr     = wr && (addr == OFS_ENABLE);
        clr_req   = chanop_wr && (wdata == CMD_ARM);
        st_d      = st_q;
        st_d.crst = 1'b0;
        if (en_wr) begin
            st_d.en = wdata[NCH-1:0];
        end
        if (chanop_wr) begin
            unique case (wdata)
                CMD_ARM: begin
                    st_d.armed = 1'b1;
                    st_d.run   = 1'b1;
                end
                CMD_DISARM: begin
                    st_d.armed = 1'b0;
                    st_d.crst  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_mask = st_q.en;
    assign armed   = st_q.armed;
    assign run     = st_q.run;
    assign crst    = st_q.crst;
endmodule

// File: rtl/cnt_irq_pend.sv
module cnt_irq_pend
    import cnt_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] flag,
    input  logic [NCH-1:0] en_mask,
    input  logic           clr_req,
    output logic [NCH-1:0] pend
);
    logic [NCH-1:0] pend_d, pend_q;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        always_comb begin
            pend_d[n] = (pend_q[n] && !clr_req) || (flag[n] && en_mask[n]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/cnt_irq_agg.sv
module cnt_irq_agg
    import cnt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    flag_i,
    output logic              count_run_o,
    output logic              count_rst_o,
    output logic              irq_o
);
    logic [NCH-1:0] en_mask;
    logic [NCH-1:0] pend_q;
    logic           armed_q;
    logic           clr_req;

    cnt_irq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .en_mask (en_mask),
        .armed   (armed_q),
        .run     (count_run_o),
        .crst    (count_rst_o),
        .clr_req (clr_req)
    );

    cnt_irq_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag    (flag_i),
        .en_mask (en_mask),
        .clr_req (clr_req),
        .pend    (pend_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_STATUS) begin
            bus_rdata[NCH-1:0] = pend_q;
        end else if (bus_addr == OFS_ENABLE) begin
            bus_rdata[NCH-1:0] = en_mask;
        end
    end

    assign irq_o = armed_q && (|pend_q);
endmodule

// File: rtl/cnt_irq_agg_chk.sv
module cnt_irq_agg_chk
    import cnt_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NCH-1:0]    flag,
    input logic [NCH-1:0]    en_mask,
    input logic [NCH-1:0]    pend,
    input logic              irq,
    input logic              crst
);
    logic           arm_cmd, disarm_cmd;
    logic [NCH-1:0] hit;
    assign arm_cmd    = wr && addr == OFS_CHANOP && wdata == CMD_ARM;
    assign disarm_cmd = wr && addr == OFS_CHANOP && wdata == CMD_DISARM;
    assign hit        = flag & en_mask;

    AST_LATCH_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(hit)) == $past(hit))); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_cmd |=> ((pend & $past(pend)) == $past(pend))); // R5
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_cmd |=> (pend == $past(hit))); // R7
    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_cmd |=> (!irq && crst)); // R8
    AST_CRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        crst |=> !crst); // R8
    AST_SHARED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq); // R9
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_ENABLE) |=> (en_mask == $past(wdata[NCH-1:0]))); // R3
endmodule

bind cnt_irq_agg cnt_irq_agg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .flag    (flag_i),
    .en_mask (en_mask),
    .pend    (pend_q),
    .irq     (irq_o),
    .crst    (count_rst_o)
);

// File: tb/cnt_irq_agg_tb_top.sv
module cnt_irq_agg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = 5'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] flag_i = 8'h00;
    logic       count_run_o, count_rst_o, irq_o;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cnt_irq_agg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .flag_i      (flag_i),
        .count_run_o (count_run_o),
        .count_rst_o (count_rst_o),
        .irq_o       (irq_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // called at a negedge; returns the combinational read value
    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // starts and ends at a negedge; one clock edge captures the write
    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input logic [7:0] flags);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        flag_i    = flags;
        @(negedge clk);
        bus_wr    = 1'b0;
        flag_i    = 8'h00;
    endtask

    task automatic pulse_flags(input logic [7:0] flags);
        flag_i = flags;
        @(negedge clk);
        flag_i = 8'h00;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(5'h10, v); check("R1 status", v, 8'h00);
        rd(5'h12, v); check("R1 enable", v, 8'h00);
        check("R1 outputs", {5'b0, irq_o, count_run_o, count_rst_o}, 8'h00);
    endtask

    task automatic t_enable_latch();
        logic [7:0] v;
        wr_reg(5'h12, 8'h05, 8'h00);
        rd(5'h12, v); check("R3 enable readback", v, 8'h05);
        pulse_flags(8'hFF);
        rd(5'h10, v); check("R4 R3 masked latch", v, 8'h05);
        check("R9 irq while disarmed", {7'b0, irq_o}, 8'h00);
        wr_reg(5'h11, 8'h04, 8'h00);
        rd(5'h10, v); check("R6 arm clears", v, 8'h00);
        check("R6 run", {7'b0, count_run_o}, 8'h01);
        check("R9 no pending no irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        pulse_flags(8'h04);
        rd(5'h10, v); check("R2 status bit 2", v, 8'h04);
        check("R9 irq armed", {7'b0, irq_o}, 8'h01);
        repeat (3) @(negedge clk);
        rd(5'h10, v); check("R5 sticky", v, 8'h04);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr_reg(5'h11, 8'h04, 8'h01);
        rd(5'h10, v); check("R7 flag beats clear", v, 8'h01);
        check("R9 irq after overlap", {7'b0, irq_o}, 8'h01);
    endtask

    task automatic t_disarm();
        logic [7:0] v;
        wr_reg(5'h11, 8'h01, 8'h00);
        check("R8 reset pulse", {7'b0, count_rst_o}, 8'h01);
        check("R8 irq drops", {7'b0, irq_o}, 8'h00);
        rd(5'h10, v); check("R8 pending kept", v, 8'h01);
        check("R8 run kept", {7'b0, count_run_o}, 8'h01);
        @(negedge clk);
        check("R8 pulse one cycle", {7'b0, count_rst_o}, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        wr_reg(5'h11, 8'h02, 8'h00);
        wr_reg(5'h13, 8'hFF, 8'h00);
        wr_reg(5'h10, 8'hFF, 8'h00);
        rd(5'h10, v); check("R10 status unchanged", v, 8'h01);
        rd(5'h12, v); check("R10 enable unchanged", v, 8'h05);
        check("R10 outputs unchanged", {5'b0, irq_o, count_run_o, count_rst_o}, 8'h02);
        wr_reg(5'h12, 8'h00, 8'h00);
        pulse_flags(8'hFF);
        rd(5'h10, v); check("R3 all disabled", v, 8'h01);
    endtask

    task automatic t_pattern();
        logic [7:0] v;
        wr_reg(5'h11, 8'h04, 8'h00);
        rd(5'h10, v); check("R6 rearm clears", v, 8'h00);
        wr_reg(5'h12, 8'hF0, 8'h00);
        pulse_flags(8'h0F);
        rd(5'h10, v); check("R3 low half masked", v, 8'h00);
        check("R9 quiet", {7'b0, irq_o}, 8'h00);
        pulse_flags(8'hA0);
        pulse_flags(8'h40);
        rd(5'h10, v); check("R2 R4 pattern", v, 8'hE0);
        check("R9 irq pattern", {7'b0, irq_o}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_latch();
        t_sticky();
        t_same_cycle();
        t_disarm();
        t_ignored();
        t_pattern();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule